// File: doc/BRIEF.md
# Condition Test and Byte Set

This unit evaluates one of sixteen conditions against a set of four arithmetic flags: negative, zero, overflow and carry. The conditions cover unsigned comparisons, signed comparisons, single-flag tests, and a constant true and a constant false. The outcome is shown as a single combinational bit. When a valid strobe is present, the outcome is also captured as a byte mask that is all ones when the condition holds and all zeros when it does not.

The unit only reads the flags. It has no path that drives them. Address generation and the memory write of the byte are left to the surrounding datapath, which takes `mask_o` one clock after it raised `valid_i`.

Top module: `cond_byte_set`

## Requirements
- R1: After the asynchronous reset `rst_ni` is asserted, `mask_o` is 0x00.
- R2: Selector 0 (always) makes `cond_o` 1 for every flag pattern. Selector 1 (never) makes `cond_o` 0 for every flag pattern.
- R3: Selector 2 (higher) is true when C=0 and Z=0. Selector 3 (lower or same) is true when C=1 or Z=1.
- R4: Selector 4 is true when C=0 and selector 5 when C=1. Selector 6 is true when Z=0 and selector 7 when Z=1.
- R5: Selector 8 is true when V=0 and selector 9 when V=1. Selector 10 is true when N=0 and selector 11 when N=1.
- R6: Selector 12 (signed greater or equal) is true when N equals V. Selector 13 (signed less) is true when N differs from V.
- R7: Selector 14 (signed greater) is true when N equals V and Z=0. Selector 15 (signed less or equal) is true when Z=1 or N differs from V.
- R8: `cond_o` follows the selector and the flags in the same cycle, whether or not `valid_i` is high.
- R9: At a rising edge where `valid_i` is 1, `mask_o` is loaded with 0xFF if the condition is true and with 0x00 otherwise. `mask_o` is never any other value.
- R10: At a rising edge where `valid_i` is 0, `mask_o` keeps its value, even if the selector or the flags change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Capture strobe for the byte mask |
| cond_sel_i | input | 4 | Condition selector, encoded as 0 to 15 as listed in R2 to R7 |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_v_i | input | 1 | Overflow flag |
| flag_c_i | input | 1 | Carry flag |
| cond_o | output | 1 | Combinational result of the condition |
| mask_o | output | 8 | Registered byte mask |

## Verification
`cond_o` is due in the same cycle as its inputs. `mask_o` is due after the first rising edge that sees `valid_i` high. The bench drives its inputs just after a falling edge and checks `cond_o` one nanosecond later. A monitor compares `mask_o` at every falling edge against the head of the scoreboard queue, so each expected byte is checked half a cycle after the edge that should have loaded it. In cycles without a strobe, the monitor compares against the last byte that was loaded, which is how it checks the hold behaviour.

// File: rtl/cond_byte_pkg.sv
package cond_byte_pkg;
  localparam int unsigned SEL_W = 4;

  typedef enum logic [SEL_W-1:0] {
    CND_T  = 4'd0,  CND_F  = 4'd1,
    CND_HI = 4'd2,  CND_LS = 4'd3,
    CND_CC = 4'd4,  CND_CS = 4'd5,
    CND_NE = 4'd6,  CND_EQ = 4'd7,
    CND_VC = 4'd8,  CND_VS = 4'd9,
    CND_PL = 4'd10, CND_MI = 4'd11,
    CND_GE = 4'd12, CND_LT = 4'd13,
    CND_GT = 4'd14, CND_LE = 4'd15
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;
endpackage

// File: rtl/cond_eval.sv
module cond_eval
  import cond_byte_pkg::*;
(
  input  cond_e  sel_i,
  input  flags_t flg_i,
  output logic   hit_o
);
  logic base;
  logic sgn_lt;

  assign sgn_lt = flg_i.n ^ flg_i.v;

  // each odd selector is the inverse of its even neighbour
  always_comb begin
    unique case (sel_i[SEL_W-1:1])
      3'd0:    base = 1'b1;
      3'd1:    base = ~(flg_i.c | flg_i.z);
      3'd2:    base = ~flg_i.c;
      3'd3:    base = ~flg_i.z;
      3'd4:    base = ~flg_i.v;
      3'd5:    base = ~flg_i.n;
      3'd6:    base = ~sgn_lt;
      default: base = ~(sgn_lt | flg_i.z);
    endcase
  end

  assign hit_o = base ^ sel_i[0];

  always_comb begin
    p_always_r2: assert (sel_i != CND_T || hit_o);
    p_never_r2:  assert (sel_i != CND_F || !hit_o);
    p_eq_r4:     assert (sel_i != CND_EQ || hit_o == flg_i.z);
    p_hi_r3:     assert (!(sel_i == CND_HI && hit_o) || (!flg_i.c && !flg_i.z));
    p_gt_r7:     assert (!(sel_i == CND_GT && hit_o) || !flg_i.z);
    p_ge_r6:     assert (sel_i != CND_GE || hit_o == (flg_i.n == flg_i.v));
  end
endmodule

// File: rtl/mask_reg.sv
module mask_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             bit_i,
  output logic [WIDTH-1:0] mask_o
);
  logic [WIDTH-1:0] mask_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     mask_q[g] <= 1'b0;
      else if (load_i) mask_q[g] <= bit_i;
    end
  end

  assign mask_o = mask_q;

  p_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> mask_o == {WIDTH{$past(bit_i)}});
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(mask_o));
  p_uniform_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_o == '0 || mask_o == '1);
endmodule

// File: rtl/cond_byte_set.sv
module cond_byte_set
  import cond_byte_pkg::*;
#(
  parameter int unsigned MASK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [SEL_W-1:0]  cond_sel_i,
  input  logic              flag_n_i,
  input  logic              flag_z_i,
  input  logic              flag_v_i,
  input  logic              flag_c_i,
  output logic              cond_o,
  output logic [MASK_W-1:0] mask_o
);
  flags_t flg;
  logic   hit;

  assign flg = '{n: flag_n_i, z: flag_z_i, v: flag_v_i, c: flag_c_i};

  cond_eval i_eval (
    .sel_i (cond_e'(cond_sel_i)),
    .flg_i (flg),
    .hit_o (hit)
  );

  mask_reg #(.WIDTH(MASK_W)) i_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (valid_i),
    .bit_i  (hit),
    .mask_o (mask_o)
  );

  assign cond_o = hit;

  p_pair_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_sel_i == 4'd5) |-> cond_o == flag_c_i);
endmodule

// File: tb/test_cond_byte_set.sv
module test_cond_byte_set;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [3:0] sel = '0;
  logic       fn = 1'b0, fz = 1'b0, fv = 1'b0, fc = 1'b0;
  logic       cond;
  logic [7:0] mask;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];
  logic [7:0] cur_exp = 8'h00;
  logic       pend = 1'b0;
  logic       mon_on = 1'b0;
  logic       reported = 1'b0;

  always #4 clk = ~clk;

  cond_byte_set i_cond_byte_set (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .cond_sel_i(sel),
    .flag_n_i(fn), .flag_z_i(fz), .flag_v_i(fv), .flag_c_i(fc),
    .cond_o(cond), .mask_o(mask)
  );

  function automatic logic model(input logic [3:0] s, input logic n, z, v, c);
    case (s)
      4'd0:  return 1'b1;
      4'd1:  return 1'b0;
      4'd2:  return !c && !z;
      4'd3:  return c || z;
      4'd4:  return !c;
      4'd5:  return c;
      4'd6:  return !z;
      4'd7:  return z;
      4'd8:  return !v;
      4'd9:  return v;
      4'd10: return !n;
      4'd11: return n;
      4'd12: return n == v;
      4'd13: return n != v;
      4'd14: return (n == v) && !z;
      default: return z || (n != v);
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] s);
    case (s)
      4'd0, 4'd1:   return "R2";
      4'd2, 4'd3:   return "R3";
      4'd4, 4'd5, 4'd6, 4'd7: return "R4";
      4'd8, 4'd9, 4'd10, 4'd11: return "R5";
      4'd12, 4'd13: return "R6";
      default:      return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!reported) begin
      reported = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
    $finish;
  endtask

  // driver: apply at falling edge, check combinational bit, queue expected mask
  task automatic drive(input logic [3:0] s, input logic [3:0] f, input logic v_in,
                       input string tag);
    logic e;
    @(negedge clk);
    sel = s; {fn, fz, fv, fc} = f; valid = v_in;
    e = model(s, f[3], f[2], f[1], f[0]);
    #1;
    check(tag, {7'd0, cond}, {7'd0, e});
    if (v_in) exp_q.push_back({8{e}});
  endtask

  always @(posedge clk) pend <= valid;

  // monitor: compare mask each falling edge
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      if (pend) begin
        if (exp_q.size() > 0) cur_exp = exp_q.pop_front();
        check("R9", mask, cur_exp);
      end else begin
        check("R10", mask, cur_exp);
      end
    end
  end

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1", mask, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", mask, 8'h00);
    mon_on = 1'b1;

    // every selector against every flag pattern, strobed (R2..R7, R9)
    for (int s = 0; s < 16; s++)
      for (int f = 0; f < 16; f++)
        drive(s[3:0], f[3:0], 1'b1, req_of(s[3:0]));

    // unstrobed changes: cond_o live (R8), mask held (R10)
    drive(4'd0, 4'h0, 1'b1, "R2");
    for (int k = 0; k < 16; k++) drive(k[3:0], 4'(15 - k), 1'b0, "R8");
    drive(4'd1, 4'h0, 1'b1, "R2");
    for (int k = 0; k < 8; k++) drive(4'd0, k[3:0], 1'b0, "R8");

    // alternating strobes between true and false conditions (R9)
    for (int k = 0; k < 10; k++) drive(4'd7, {2'b0, k[0], 1'b0} << 1, k[1], "R4");

    // reset mid-run clears the mask (R1)
    @(negedge clk);
    valid = 1'b0;
    mon_on = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", mask, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    exp_q.delete();
    cur_exp = 8'h00;
    repeat (2) @(negedge clk);
    check("R1", mask, 8'h00);
    finish_run();
  end
endmodule